// File: doc/BRIEF.md
# I2S/TDM Serial Audio Transmitter

This block is the serial master for outgoing audio. It makes the bit clock and the frame signal by dividing the system clock. It takes parallel samples through a valid/ready handshake and shifts them out on a data line that has a separate output-enable. The frame signal works in one of two ways. In two-channel mode it is a left/right clock, and its polarity can be set. In multi-slot mode it is a sync pulse of programmable width, and a frame holds up to eight slots. Static configuration inputs set the slot length, the data offset, the container size, the trimmed low bits, the bit order, the launch edge, the per-slot enables and how the line behaves in slots that carry no data.

The sequencer is a small state machine that moves once per bit period. S_IDLE holds from reset until the first bit period starts. After that, every bit period lands in one of four states, picked from the position of the next bit:
- S_MUTE: the slot is disabled.
- S_LEAD: the bit comes before the data offset.
- S_DATA: the bit lies inside the sample window.
- S_TAIL: the bit comes after the sample.

Any state can move to any of the four on each bit-period boundary. S_IDLE is left on the first boundary and is never entered again without a reset.

Top module: `i2s_tdm_tx`

## Requirements
- R1: One bit period is 2*HALF_DIV system cycles. All data and frame changes occur at the start of a bit period (the launch edge). If `cfg_neg_launch`=0, `bclk` rises at that point. If it is 1, `bclk` falls. Before the first bit period `bclk` rests at the level `cfg_neg_launch`.
- R2: With `cfg_frame_mode`=0 a frame has two slots (0 = left, 1 = right), whatever the value of `cfg_slot_last`. `fsync` equals the slot index XOR `cfg_lr_pol`, so with polarity 0 the left slot is sent while `fsync` is low.
- R3: With `cfg_frame_mode`=1 a frame has `cfg_slot_last`+1 slots. `fsync` is high for the first `cfg_sync_len`+1 bit periods of each frame and low for the rest.
- R4: Each slot lasts `cfg_slot_bits`+1 bit periods. Slots follow one another without gaps, and frames repeat without gaps.
- R5: In an enabled slot the first data bit is sent at bit position `cfg_lead` of the slot. Bits before and after the sample window are driven as 0 with `sdata_oe`=1.
- R6: The container width is 4*code+4 bits for `cfg_container` codes 1 to 7 (8 to 32 bits), and code 0 is treated as 8 bits. The block sends container minus `cfg_trim` bits, taken from bits [container-1 : trim] of the sample. Bits above the container are ignored.
- R7: With `cfg_lsb_first`=0 the sample goes out most significant bit first. With `cfg_lsb_first`=1 it goes out least significant bit first.
- R8: `s_ready` is high for exactly the one system cycle that ends just before bit 0 of an enabled slot. A sample moves when `s_valid` and `s_ready` are both high. Disabled slots take no sample.
- R9: If `s_valid` is low while `s_ready` is high, the slot sends only zeros. `underrun` is then high for the one cycle in which that slot's bit 0 appears.
- R10: Idle policy `cfg_idle_mode`=0: a disabled slot drives `sdata`=0 with `sdata_oe`=1.
- R11: Idle policy 1 or 3: `sdata_oe` is 0 for the whole disabled slot.
- R12: Idle policy 2: entering a disabled slot straight from a driven bit keeps `sdata_oe`=1 (with `sdata`=0) for the first HALF_DIV cycles, then releases it. A line that is already released stays released.
- R13: During reset and until the first bit period, `sdata`, `sdata_oe`, `fsync` and `underrun` are 0. The first bit (slot 0, bit 0) appears 2*HALF_DIV cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_frame_mode | input | 1 | 0 = left/right clock, 1 = sync pulse with multiple slots |
| cfg_lr_pol | input | 1 | Left/right polarity (0: left sent while low) |
| cfg_sync_len | input | 8 | Sync pulse length minus one, in bit periods |
| cfg_slot_last | input | 3 | Slots per frame minus one (pulse mode) |
| cfg_slot_en | input | 8 | Bit n enables slot n |
| cfg_lsb_first | input | 1 | 0 = MSB first, 1 = LSB first |
| cfg_neg_launch | input | 1 | 0 = data launched on rising bclk, 1 = on falling |
| cfg_container | input | 3 | Container code (width 4*code+4) |
| cfg_trim | input | 3 | Low bits dropped from the container |
| cfg_slot_bits | input | 11 | Bit periods per slot minus one |
| cfg_lead | input | 11 | Bit periods from slot start to the first data bit |
| cfg_idle_mode | input | 2 | Line policy for disabled slots |
| s_data | input | 32 | Sample, right-aligned in the container |
| s_valid | input | 1 | Sample available |
| s_ready | output | 1 | Sample taken this cycle |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Left/right clock or frame sync pulse |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Output enable for `sdata` |
| underrun | output | 1 | One-cycle pulse for a slot started without a sample |

## Verification
The bench runs seven configurations against a behavioural model that works out every output from the global bit index and the system-cycle phase. Two-channel runs with both polarities, both bit orders and both launch edges show that the frame clock is placed correctly against the data offset. Multi-slot runs use sparse enable masks, including a single enabled slot followed by runs of disabled slots. These tell the three idle policies apart, including the case where the line is held for half a bit and the case where it stays released. A `s_valid` input that drops out in a pattern unrelated to slot starts produces underrun slots. Those slots must carry zeros and must not use up a queued sample. A spread of container codes (including code 0), trim values and offsets, some pushing the sample window close to the slot end, checks the width, the trim and the alignment of each sample.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
    localparam int SAMPLE_W = 32;
    localparam int CNT_W    = 11;
    localparam int SLOT_W   = 3;
    localparam int NSLOT    = 1 << SLOT_W;
    localparam int FBIT_W   = CNT_W + SLOT_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_DATA,
        S_TAIL,
        S_MUTE
    } tx_state_e;

    // container width in bits; code 0 is treated as the narrowest width
    function automatic logic [5:0] container_bits(input logic [2:0] code);
        return (code == 3'd0) ? 6'd8 : ({1'b0, code, 2'b00} + 6'd4);
    endfunction
endpackage

// File: rtl/i2s_tx_clkdiv.sv
`timescale 1ns/1ps
module i2s_tx_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic neg_launch,
    output logic tick,
    output logic half_tick,
    output logic bclk
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int PH_W   = $clog2(PERIOD);

    logic [PH_W-1:0] ph_q, ph_n;
    logic            run_q;

    assign tick      = (ph_q == PH_W'(PERIOD - 1));
    assign half_tick = (ph_q == PH_W'(HALF_DIV - 1));
    assign ph_n      = tick ? '0 : ph_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            run_q <= 1'b0;
            bclk  <= 1'b0;
        end else begin
            ph_q  <= ph_n;
            run_q <= run_q | tick;
            bclk  <= (run_q | tick) ? ((ph_n < PH_W'(HALF_DIV)) ^ neg_launch) : neg_launch;
        end
    end
endmodule

// File: rtl/i2s_tx_pos.sv
`timescale 1ns/1ps
module i2s_tx_pos
    import i2s_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  slot_bits,
    input  logic [SLOT_W-1:0] slot_last,
    output logic [SLOT_W-1:0] nxt_slot,
    output logic [CNT_W-1:0]  nxt_bit,
    output logic [FBIT_W-1:0] nxt_fbit
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_slot <= '0;
            nxt_bit  <= '0;
            nxt_fbit <= '0;
        end else if (tick) begin
            if (nxt_bit == slot_bits) begin
                nxt_bit <= '0;
                if (nxt_slot == slot_last) begin
                    nxt_slot <= '0;
                    nxt_fbit <= '0;
                end else begin
                    nxt_slot <= nxt_slot + 1'b1;
                    nxt_fbit <= nxt_fbit + 1'b1;
                end
            end else begin
                nxt_bit  <= nxt_bit + 1'b1;
                nxt_fbit <= nxt_fbit + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2s_tdm_tx.sv
`timescale 1ns/1ps
module i2s_tdm_tx
    import i2s_tx_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_frame_mode,
    input  logic                cfg_lr_pol,
    input  logic [7:0]          cfg_sync_len,
    input  logic [SLOT_W-1:0]   cfg_slot_last,
    input  logic [NSLOT-1:0]    cfg_slot_en,
    input  logic                cfg_lsb_first,
    input  logic                cfg_neg_launch,
    input  logic [2:0]          cfg_container,
    input  logic [2:0]          cfg_trim,
    input  logic [CNT_W-1:0]    cfg_slot_bits,
    input  logic [CNT_W-1:0]    cfg_lead,
    input  logic [1:0]          cfg_idle_mode,
    input  logic [SAMPLE_W-1:0] s_data,
    input  logic                s_valid,
    output logic                s_ready,
    output logic                bclk,
    output logic                fsync,
    output logic                sdata,
    output logic                sdata_oe,
    output logic                underrun
);
    logic              tick, half_tick;
    logic [SLOT_W-1:0] nxt_slot, eff_last;
    logic [CNT_W-1:0]  nxt_bit;
    logic [FBIT_W-1:0] nxt_fbit;

    tx_state_e st_q, st_n;
    logic [SAMPLE_W-1:0] sh_q, src, load_v, samp_in;
    logic [5:0]  cont, eff_len;
    logic [CNT_W:0] data_end;
    logic slot_on, slot_start;

    i2s_tx_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .neg_launch(cfg_neg_launch),
        .tick(tick), .half_tick(half_tick), .bclk(bclk)
    );

    assign eff_last = cfg_frame_mode ? cfg_slot_last : SLOT_W'(1);

    i2s_tx_pos u_pos (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .slot_bits(cfg_slot_bits), .slot_last(eff_last),
        .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_fbit(nxt_fbit)
    );

    assign cont       = container_bits(cfg_container);
    assign eff_len    = cont - {3'b000, cfg_trim};
    assign data_end   = {1'b0, cfg_lead} + {{(CNT_W-5){1'b0}}, eff_len};
    assign slot_on    = cfg_slot_en[nxt_slot];
    assign slot_start = (nxt_bit == '0) && slot_on;
    assign s_ready    = tick && slot_start;

    // sample aligned so the first bit to send sits at the shift end
    assign samp_in = s_valid ? s_data : '0;
    assign load_v  = cfg_lsb_first ? (samp_in >> cfg_trim) : (samp_in << (6'd32 - cont));
    assign src     = slot_start ? load_v : sh_q;

    function automatic tx_state_e pick_state(input logic on, input logic [CNT_W-1:0] b,
                                             input logic [CNT_W-1:0] lead, input logic [CNT_W:0] dend);
        if (!on)                   return S_MUTE;
        else if (b < lead)         return S_LEAD;
        else if ({1'b0, b} < dend) return S_DATA;
        else                       return S_TAIL;
    endfunction

    // next state: every transition happens on a bit-period boundary
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            S_IDLE, S_LEAD, S_DATA, S_TAIL, S_MUTE:
                if (tick) st_n = pick_state(slot_on, nxt_bit, cfg_lead, data_end);
            default: st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_n;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            sdata    <= 1'b0;
            sdata_oe <= 1'b0;
            fsync    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= s_ready && !s_valid;
            if (tick) begin
                fsync <= cfg_frame_mode ? (nxt_fbit <= {{(FBIT_W-8){1'b0}}, cfg_sync_len})
                                        : (nxt_slot[0] ^ cfg_lr_pol);
                unique case (st_n)
                    S_DATA: begin
                        sdata    <= cfg_lsb_first ? src[0] : src[SAMPLE_W-1];
                        sh_q     <= cfg_lsb_first ? (src >> 1) : (src << 1);
                        sdata_oe <= 1'b1;
                    end
                    S_LEAD, S_TAIL: begin
                        sdata    <= 1'b0;
                        sh_q     <= src;
                        sdata_oe <= 1'b1;
                    end
                    S_MUTE: begin
                        sdata    <= 1'b0;
                        sdata_oe <= (cfg_idle_mode == 2'd0) ||
                                    ((cfg_idle_mode == 2'd2) && (st_q != S_MUTE) && (st_q != S_IDLE));
                    end
                    default: ;
                endcase
            end else if (half_tick && (st_q == S_MUTE) && (cfg_idle_mode == 2'd2)) begin
                sdata_oe <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2s_tdm_tx_chk.sv
`timescale 1ns/1ps
module i2s_tdm_tx_chk
    import i2s_tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input tx_state_e st_q,
    input logic      cfg_neg_launch,
    input logic [1:0] cfg_idle_mode,
    input logic      s_valid,
    input logic      s_ready,
    input logic      bclk,
    input logic      fsync,
    input logic      sdata,
    input logic      sdata_oe,
    input logic      underrun
);
    // R1
    launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE && !$stable(sdata)) |-> (bclk != cfg_neg_launch));
    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);
    // R9
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(s_ready && !s_valid));
    // R9
    underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!sdata && sdata_oe));
    // R10
    drive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_MUTE && cfg_idle_mode == 2'd0) |-> (sdata_oe && !sdata));
    // R11
    hiz_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_MUTE && cfg_idle_mode[0]) |-> !sdata_oe);
    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE) |-> (!sdata_oe && !sdata && !fsync && !underrun));
endmodule

bind i2s_tdm_tx i2s_tdm_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st_q(st_q), .cfg_neg_launch(cfg_neg_launch),
    .cfg_idle_mode(cfg_idle_mode), .s_valid(s_valid), .s_ready(s_ready),
    .bclk(bclk), .fsync(fsync), .sdata(sdata), .sdata_oe(sdata_oe), .underrun(underrun)
);

// File: tb/tb_i2s_tdm_tx.sv
`timescale 1ns/1ps
module tb_i2s_tdm_tx;
    localparam int HALF = 2;
    localparam int P    = 2 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_frame_mode = 0, cfg_lr_pol = 0, cfg_lsb_first = 0, cfg_neg_launch = 0;
    logic [7:0]  cfg_sync_len = 0;
    logic [2:0]  cfg_slot_last = 0, cfg_container = 0, cfg_trim = 0;
    logic [7:0]  cfg_slot_en = 0;
    logic [10:0] cfg_slot_bits = 0, cfg_lead = 0;
    logic [1:0]  cfg_idle_mode = 0;
    logic [31:0] s_data = 0;
    logic        s_valid = 0;
    logic s_ready, bclk, fsync, sdata, sdata_oe, underrun;

    int errors = 0, checks = 0, cc = 0, vmode = 0;
    logic [31:0] cur_samp = 0, nxt_val = 32'h1234_5678;
    logic und_exp = 0;

    always #2.5 clk = ~clk;

    i2s_tdm_tx #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_frame_mode(cfg_frame_mode), .cfg_lr_pol(cfg_lr_pol),
        .cfg_sync_len(cfg_sync_len), .cfg_slot_last(cfg_slot_last), .cfg_slot_en(cfg_slot_en),
        .cfg_lsb_first(cfg_lsb_first), .cfg_neg_launch(cfg_neg_launch), .cfg_container(cfg_container),
        .cfg_trim(cfg_trim), .cfg_slot_bits(cfg_slot_bits), .cfg_lead(cfg_lead),
        .cfg_idle_mode(cfg_idle_mode), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .bclk(bclk), .fsync(fsync), .sdata(sdata), .sdata_oe(sdata_oe), .underrun(underrun)
    );

    function automatic int slen();   return int'(cfg_slot_bits) + 1; endfunction
    function automatic int nslots(); return cfg_frame_mode ? int'(cfg_slot_last) + 1 : 2; endfunction
    function automatic int cbits();  return (cfg_container == 0) ? 8 : 4 * int'(cfg_container) + 4; endfunction
    function automatic int slot_of(int g); return (g % (nslots() * slen())) / slen(); endfunction
    function automatic int bit_of(int g);  return g % slen(); endfunction
    function automatic int fbit_of(int g); return g % (nslots() * slen()); endfunction
    function automatic bit on_of(int g);   return cfg_slot_en[slot_of(g)]; endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cc);
        end
    endtask

    task automatic check_outputs();
        int ph, g, b, k, eff;
        logic e_ws, e_d, e_oe;
        string dreq, oreq;
        ph = cc % P;
        // R13 / R1: before the first bit period
        if (cc < P) begin
            chk("R1", "bclk idle", bclk, cfg_neg_launch);
            chk("R13", "fsync", fsync, 0);
            chk("R13", "sdata", sdata, 0);
            chk("R13", "oe", sdata_oe, 0);
            chk("R13", "underrun", underrun, 0);
            return;
        end
        g = cc / P - 1;
        b = bit_of(g);
        eff = cbits() - int'(cfg_trim);
        chk("R1", "bclk", bclk, (ph < HALF) ^ cfg_neg_launch);
        if (cfg_frame_mode) begin
            e_ws = (fbit_of(g) <= int'(cfg_sync_len));
            chk("R3", "fsync", fsync, e_ws);
        end else begin
            e_ws = slot_of(g)[0] ^ cfg_lr_pol;
            chk("R2", "fsync", fsync, e_ws);
        end
        e_d = 0; e_oe = 1; dreq = "R5"; oreq = "R5";
        if (on_of(g)) begin
            k = b - int'(cfg_lead);
            if (b >= int'(cfg_lead) && k < eff) begin
                e_d = cfg_lsb_first ? cur_samp[int'(cfg_trim) + k] : cur_samp[cbits() - 1 - k];
                dreq = cfg_lsb_first ? "R7" : "R6";
            end else if (b >= int'(cfg_lead)) dreq = "R4";
        end else begin
            case (cfg_idle_mode)
                2'd0: begin e_oe = 1; oreq = "R10"; end
                2'd2: begin
                    e_oe = (b == 0) && (ph < HALF) && (g > 0) && on_of(g - 1);
                    oreq = "R12";
                end
                default: begin e_oe = 0; oreq = "R11"; end
            endcase
        end
        chk(dreq, "sdata", sdata, e_d);
        chk(oreq, "sdata_oe", sdata_oe, e_oe);
        chk("R9", "underrun", underrun, und_exp);
    endtask

    task automatic step_inputs();
        int g;
        bit e_r;
        s_valid = (vmode == 0) ? 1'b1 : (((cc / (P * 5)) % 3) != 0);
        s_data  = nxt_val;
        e_r = 0;
        if (((cc + 1) % P) == 0) begin
            g = (cc + 1) / P - 1;
            e_r = (bit_of(g) == 0) && on_of(g);
        end
        chk("R8", "s_ready", s_ready, e_r);
        und_exp = e_r && !s_valid;
        if (e_r) begin
            if (s_valid) begin
                cur_samp = nxt_val;
                nxt_val  = nxt_val * 32'd1664525 + 32'd1013904223;
            end else cur_samp = 0;
        end
    endtask

    task automatic run_cfg(input bit fm, input bit pol, input int sync, input int last, input int en,
                           input bit lsb, input bit neg, input int cont, input int trim, input int sbits,
                           input int lead, input int idle, input int vm, input int nbits);
        rst_n = 0;
        cfg_frame_mode = fm; cfg_lr_pol = pol; cfg_sync_len = 8'(sync); cfg_slot_last = 3'(last);
        cfg_slot_en = 8'(en); cfg_lsb_first = lsb; cfg_neg_launch = neg; cfg_container = 3'(cont);
        cfg_trim = 3'(trim); cfg_slot_bits = 11'(sbits); cfg_lead = 11'(lead); cfg_idle_mode = 2'(idle);
        vmode = vm; s_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: reset state
        chk("R13", "reset sdata", sdata, 0);
        chk("R13", "reset oe", sdata_oe, 0);
        chk("R13", "reset fsync", fsync, 0);
        chk("R13", "reset underrun", underrun, 0);
        chk("R13", "reset ready", s_ready, 0);
        chk("R13", "reset bclk", bclk, 0);
        cc = 0; und_exp = 0; cur_samp = 0;
        rst_n = 1;
        step_inputs();
        for (int i = 0; i < (nbits + 1) * P; i++) begin
            @(posedge clk);
            cc++;
            @(negedge clk);
            check_outputs();
            step_inputs();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // two-channel, offset 1, 16-bit container, MSB first, rising launch
        run_cfg(0, 0, 0, 0, 'h03, 0, 0, 3, 0, 15, 1, 0, 0, 100);
        // two-channel, inverted polarity, LSB first, falling launch, 24-bit with trim 4
        run_cfg(0, 1, 0, 5, 'h03, 1, 1, 5, 4, 31, 0, 0, 0, 140);
        // four slots, slot 2 off, half-bit release, starving source
        run_cfg(1, 0, 0, 3, 'h0B, 0, 0, 1, 2, 7, 0, 2, 1, 200);
        // eight slots, sparse mask, hi-Z policy, wide sync, starving source
        run_cfg(1, 0, 3, 7, 'h5A, 0, 1, 2, 0, 11, 2, 1, 1, 300);
        // three slots, one enabled, drive policy, 32-bit with trim 7, LSB first
        run_cfg(1, 0, 0, 2, 'h02, 1, 0, 7, 7, 39, 3, 0, 0, 260);
        // single enabled slot then disabled run, half-bit policy, container code 0
        run_cfg(1, 0, 5, 3, 'h01, 0, 0, 0, 0, 9, 1, 2, 0, 120);
        // policy code 3 behaves as hi-Z (R11)
        run_cfg(1, 0, 1, 1, 'h02, 1, 1, 4, 3, 19, 2, 3, 1, 120);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule